// File: doc/BRIEF.md
# Size-Steered Value Request Router

This block sits in the value-store stage of a streaming key-value pipeline. Each incoming value request, whether a read (GET) or a write (SET), carries a length and a tag. The block compares the length with a programmable threshold. Short values go to a fast, low-latency memory port. Long values go to a slow, page-oriented port, and their transfer length is rounded up to a whole number of pages. The steering is a pass-through: a request is accepted in the same cycle that the chosen back end takes it.

Responses return from the two back ends as tagged, possibly multi-beat packets. A merger forwards them onto one output as soon as they are available, with no regard for request order. Fast results therefore overtake slow ones that are still outstanding. When both ports hold a packet at the same time, the merger alternates between them. Once a packet has started on the output, it runs to its last beat before the other port may use the output.

Each port has its own limit on outstanding requests. A full port stalls only the requests steered to it. A new threshold written by software is parked until both ports are drained, so no request that is in flight is reclassified.

Top module: `kv_size_router`

## Requirements
- R1: A request whose length is strictly below the active threshold is offered on the fast port, with its length, tag and write flag unchanged. `fast_valid` is high only when `req_valid` is high, no threshold update is pending and the fast port is below its limit.
- R2: A request whose length is at or above the active threshold is offered on the slow port, with its tag and write flag unchanged. Its length is rounded up to the next multiple of 2^PAGE_LOG2 bytes (4096 by default); a length that is already a multiple is left as it is.
- R3: After reset the active threshold `cfg_thresh` is 2^PAGE_LOG2 (4096). A pulse on `cfg_wr` parks `cfg_val`, and a later write overrides an earlier one. The parked value becomes active on the first clock edge at which no write is present and both ports have zero outstanding requests. It is visible on `cfg_thresh` from the next cycle. While a value is parked, `req_ready` is low and neither port is offered a request.
- R4: Each port counts the requests it has accepted and not yet answered with a final beat, up to MAX_OUT (4). While a port's count is at MAX_OUT, requests steered to that port see `req_ready` low, and requests for the other port are still accepted. `req_ready` equals the target port's ready when that port is below its limit and no update is pending.
- R5: Responses are forwarded with no ordering against requests. A fast-port packet is passed through while slow requests are still outstanding.
- R6: Response data, tag and last flag are passed through unchanged from the selected port. `rsp_from_slow` is 1 for slow-port packets and 0 for fast-port packets. A port's ready input (`fr_ready`/`sr_ready`) follows `rsp_ready` only while that port is selected.
- R7: When no packet is in progress and both ports present a response, the port that did not finish the most recent packet wins. After reset, the fast port wins.
- R8: Once the first beat of a multi-beat packet has been accepted, the output stays with that port until its last beat has been accepted.
- R9: While `rsp_valid` is high and `rsp_ready` is low, the selected port and the presented tag do not change on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_val | input | LENW | Threshold value to park |
| cfg_thresh | output | LENW | Active threshold |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_write | input | 1 | 1 = SET, 0 = GET |
| req_len | input | LENW | Value length in bytes |
| req_tag | input | TAGW | Request tag |
| fast_valid | output | 1 | Fast-port request valid |
| fast_ready | input | 1 | Fast port can take a request |
| fast_write | output | 1 | Fast-port write flag |
| fast_len | output | LENW | Fast-port length |
| fast_tag | output | TAGW | Fast-port tag |
| slow_valid | output | 1 | Slow-port request valid |
| slow_ready | input | 1 | Slow port can take a request |
| slow_write | output | 1 | Slow-port write flag |
| slow_len | output | LENW+1 | Page-rounded slow-port length |
| slow_tag | output | TAGW | Slow-port tag |
| fr_valid | input | 1 | Fast-port response beat valid |
| fr_ready | output | 1 | Fast-port response beat taken |
| fr_data | input | DW | Fast-port response data |
| fr_tag | input | TAGW | Fast-port response tag |
| fr_last | input | 1 | Final beat of fast-port packet |
| sr_valid | input | 1 | Slow-port response beat valid |
| sr_ready | output | 1 | Slow-port response beat taken |
| sr_data | input | DW | Slow-port response data |
| sr_tag | input | TAGW | Slow-port response tag |
| sr_last | input | 1 | Final beat of slow-port packet |
| rsp_valid | output | 1 | Merged response beat valid |
| rsp_ready | input | 1 | Downstream takes the beat |
| rsp_data | output | DW | Merged response data |
| rsp_tag | output | TAGW | Merged response tag |
| rsp_last | output | 1 | Final beat of merged packet |
| rsp_from_slow | output | 1 | Beat came from the slow port |

## Verification
Every steering output, every ready signal and the merged response are combinational functions of the current inputs and the registered state. They are therefore due in the same cycle as the stimulus. The bench drives inputs at the falling edge and compares all outputs 1 ns later against its own behavioural model. Counter, arbitration and lock state change at the rising edge, so their effects are due one cycle after the handshake that caused them. A parked threshold appears one cycle after the first edge at which the bench's model sees both ports idle. The bench advances its model only after each compare, which keeps it aligned with these one-cycle delays.

// File: rtl/kvsr_pkg.sv
package kvsr_pkg;
  typedef enum logic {
    SRC_FAST = 1'b0,
    SRC_SLOW = 1'b1
  } src_e;

  localparam int NPATH = 2;
endpackage

// File: rtl/kvsr_thresh.sv
module kvsr_thresh #(
  parameter int LENW    = 20,
  parameter int RST_VAL = 4096
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_i,
  input  logic [LENW-1:0] val_i,
  input  logic            idle_i,
  output logic [LENW-1:0] thresh_o,
  output logic            pend_o
);
  logic [LENW-1:0] thr_q, thr_d;
  logic [LENW-1:0] park_q, park_d;
  logic            pend_q, pend_d;
  logic            thr_en, park_en, pend_en;

  always_comb begin
    thr_d   = thr_q;
    park_d  = park_q;
    pend_d  = pend_q;
    thr_en  = 1'b0;
    park_en = 1'b0;
    pend_en = 1'b0;
    if (wr_i) begin
      park_d  = val_i;
      park_en = 1'b1;
      pend_d  = 1'b1;
      pend_en = 1'b1;
    end else if (pend_q && idle_i) begin
      thr_d   = park_q;
      thr_en  = 1'b1;
      pend_d  = 1'b0;
      pend_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q  <= LENW'(RST_VAL);
      park_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (thr_en)  thr_q  <= thr_d;
      if (park_en) park_q <= park_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign thresh_o = thr_q;
  assign pend_o   = pend_q;

  // R3: the active threshold only moves after an idle edge
  assert_apply_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != $past(thr_q)) |-> $past(idle_i));
  // R3: a write is never lost, it leaves an update parked
  assert_park_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> pend_q);
endmodule

// File: rtl/kvsr_credit.sv
module kvsr_credit #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic full_o,
  output logic zero_o
);
  localparam int CNTW = $clog2(MAX_OUT + 1);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = inc_i ^ dec_i;
    if (inc_i && !dec_i)      cnt_d = cnt_q + 1'b1;
    else if (dec_i && !inc_i) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign full_o = (cnt_q == CNTW'(MAX_OUT));
  assign zero_o = (cnt_q == '0);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(MAX_OUT));
  assert_full_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> !inc_i);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o |-> !(dec_i && !inc_i));
endmodule

// File: rtl/kvsr_route.sv
module kvsr_route #(
  parameter int LENW      = 20,
  parameter int TAGW      = 6,
  parameter int PAGE_LOG2 = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic            req_write_i,
  input  logic [LENW-1:0] req_len_i,
  input  logic [TAGW-1:0] req_tag_i,
  input  logic [LENW-1:0] thresh_i,
  input  logic            pend_i,
  input  logic [1:0]      full_i,
  input  logic            fast_ready_i,
  input  logic            slow_ready_i,
  output logic            req_ready_o,
  output logic            fast_valid_o,
  output logic            fast_write_o,
  output logic [LENW-1:0] fast_len_o,
  output logic [TAGW-1:0] fast_tag_o,
  output logic            slow_valid_o,
  output logic            slow_write_o,
  output logic [LENW:0]   slow_len_o,
  output logic [TAGW-1:0] slow_tag_o,
  output logic [1:0]      inc_o
);
  localparam int SLW = LENW + 1;
  localparam logic [SLW-1:0] PAGE_M1 = SLW'((64'd1 << PAGE_LOG2) - 64'd1);

  logic           to_slow;
  logic           open;
  logic [SLW-1:0] padded;

  always_comb begin
    to_slow      = (req_len_i >= thresh_i);
    open         = req_valid_i && !pend_i;
    fast_valid_o = open && !to_slow && !full_i[0];
    slow_valid_o = open && to_slow && !full_i[1];
    req_ready_o  = !pend_i && (to_slow ? (slow_ready_i && !full_i[1])
                                       : (fast_ready_i && !full_i[0]));
    padded       = {1'b0, req_len_i} + PAGE_M1;
    slow_len_o   = {padded[SLW-1:PAGE_LOG2], {PAGE_LOG2{1'b0}}};
    inc_o[0]     = fast_valid_o && fast_ready_i;
    inc_o[1]     = slow_valid_o && slow_ready_i;
  end

  assign fast_write_o = req_write_i;
  assign fast_len_o   = req_len_i;
  assign fast_tag_o   = req_tag_i;
  assign slow_write_o = req_write_i;
  assign slow_tag_o   = req_tag_i;

  assert_fast_short_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fast_valid_o |-> (req_len_i < thresh_i) && !slow_valid_o);
  assert_slow_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    slow_valid_o |-> (slow_len_o[PAGE_LOG2-1:0] == '0)
                  && (slow_len_o >= {1'b0, req_len_i})
                  && ((slow_len_o - {1'b0, req_len_i}) <= PAGE_M1));
  assert_parked_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pend_i |-> !inc_o[0] && !inc_o[1]);
endmodule

// File: rtl/kvsr_merge.sv
module kvsr_merge
  import kvsr_pkg::*;
#(
  parameter int DW   = 64,
  parameter int TAGW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fr_valid_i,
  input  logic [DW-1:0]   fr_data_i,
  input  logic [TAGW-1:0] fr_tag_i,
  input  logic            fr_last_i,
  input  logic            sr_valid_i,
  input  logic [DW-1:0]   sr_data_i,
  input  logic [TAGW-1:0] sr_tag_i,
  input  logic            sr_last_i,
  input  logic            rsp_ready_i,
  output logic            fr_ready_o,
  output logic            sr_ready_o,
  output logic            rsp_valid_o,
  output logic [DW-1:0]   rsp_data_o,
  output logic [TAGW-1:0] rsp_tag_o,
  output logic            rsp_last_o,
  output logic            rsp_from_slow_o,
  output logic [1:0]      dec_o
);
  src_e sel, owner_q, owner_d, pref_q, pref_d;
  logic hold_q, hold_d;
  logic done;

  always_comb begin
    if (hold_q)                        sel = owner_q;
    else if (fr_valid_i && sr_valid_i) sel = pref_q;
    else if (sr_valid_i)               sel = SRC_SLOW;
    else                               sel = SRC_FAST;
  end

  always_comb begin
    if (sel == SRC_SLOW) begin
      rsp_valid_o = sr_valid_i;
      rsp_data_o  = sr_data_i;
      rsp_tag_o   = sr_tag_i;
      rsp_last_o  = sr_last_i;
    end else begin
      rsp_valid_o = fr_valid_i;
      rsp_data_o  = fr_data_i;
      rsp_tag_o   = fr_tag_i;
      rsp_last_o  = fr_last_i;
    end
    rsp_from_slow_o = (sel == SRC_SLOW);
    fr_ready_o      = rsp_ready_i && (sel == SRC_FAST);
    sr_ready_o      = rsp_ready_i && (sel == SRC_SLOW);
    done            = rsp_valid_o && rsp_ready_i && rsp_last_o;
    dec_o[0]        = done && (sel == SRC_FAST);
    dec_o[1]        = done && (sel == SRC_SLOW);
  end

  always_comb begin
    hold_d  = rsp_valid_o && !done;
    owner_d = rsp_valid_o ? sel : owner_q;
    pref_d  = pref_q;
    if (done) pref_d = (sel == SRC_SLOW) ? SRC_FAST : SRC_SLOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= 1'b0;
      owner_q <= SRC_FAST;
      pref_q  <= SRC_FAST;
    end else begin
      hold_q <= hold_d;
      if (rsp_valid_o) owner_q <= owner_d;
      if (done)        pref_q  <= pref_d;
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_ready_i) |=> rsp_valid_o && $stable(sel) && $stable(rsp_tag_o));
  assert_no_interleave_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && rsp_ready_i && !rsp_last_o) |=> (sel == $past(sel)));
  assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ((fr_valid_i && sr_valid_i) -> (sel != $past(sel))));
  assert_one_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(fr_ready_o && sr_ready_o));
endmodule

// File: rtl/kv_size_router.sv
module kv_size_router
  import kvsr_pkg::*;
#(
  parameter int DW        = 64,
  parameter int TAGW      = 6,
  parameter int LENW      = 20,
  parameter int PAGE_LOG2 = 12,
  parameter int MAX_OUT   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [LENW-1:0] cfg_val,
  output logic [LENW-1:0] cfg_thresh,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [LENW-1:0] req_len,
  input  logic [TAGW-1:0] req_tag,
  output logic            fast_valid,
  input  logic            fast_ready,
  output logic            fast_write,
  output logic [LENW-1:0] fast_len,
  output logic [TAGW-1:0] fast_tag,
  output logic            slow_valid,
  input  logic            slow_ready,
  output logic            slow_write,
  output logic [LENW:0]   slow_len,
  output logic [TAGW-1:0] slow_tag,
  input  logic            fr_valid,
  output logic            fr_ready,
  input  logic [DW-1:0]   fr_data,
  input  logic [TAGW-1:0] fr_tag,
  input  logic            fr_last,
  input  logic            sr_valid,
  output logic            sr_ready,
  input  logic [DW-1:0]   sr_data,
  input  logic [TAGW-1:0] sr_tag,
  input  logic            sr_last,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [DW-1:0]   rsp_data,
  output logic [TAGW-1:0] rsp_tag,
  output logic            rsp_last,
  output logic            rsp_from_slow
);
  localparam int PAGE_BYTES = 1 << PAGE_LOG2;

  logic [NPATH-1:0] inc, dec, full, zero;
  logic             pend;
  logic [LENW-1:0]  thresh;

  kvsr_thresh #(.LENW(LENW), .RST_VAL(PAGE_BYTES)) u_thresh (
    .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .val_i(cfg_val),
    .idle_i(&zero), .thresh_o(thresh), .pend_o(pend)
  );

  for (genvar p = 0; p < NPATH; p++) begin : g_credit
    kvsr_credit #(.MAX_OUT(MAX_OUT)) u_credit (
      .clk(clk), .rst_n(rst_n), .inc_i(inc[p]), .dec_i(dec[p]),
      .full_o(full[p]), .zero_o(zero[p])
    );
  end

  kvsr_route #(.LENW(LENW), .TAGW(TAGW), .PAGE_LOG2(PAGE_LOG2)) u_route (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_len_i(req_len),
    .req_tag_i(req_tag), .thresh_i(thresh), .pend_i(pend), .full_i(full),
    .fast_ready_i(fast_ready), .slow_ready_i(slow_ready),
    .req_ready_o(req_ready),
    .fast_valid_o(fast_valid), .fast_write_o(fast_write),
    .fast_len_o(fast_len), .fast_tag_o(fast_tag),
    .slow_valid_o(slow_valid), .slow_write_o(slow_write),
    .slow_len_o(slow_len), .slow_tag_o(slow_tag),
    .inc_o(inc)
  );

  kvsr_merge #(.DW(DW), .TAGW(TAGW)) u_merge (
    .clk(clk), .rst_n(rst_n),
    .fr_valid_i(fr_valid), .fr_data_i(fr_data), .fr_tag_i(fr_tag), .fr_last_i(fr_last),
    .sr_valid_i(sr_valid), .sr_data_i(sr_data), .sr_tag_i(sr_tag), .sr_last_i(sr_last),
    .rsp_ready_i(rsp_ready), .fr_ready_o(fr_ready), .sr_ready_o(sr_ready),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .rsp_tag_o(rsp_tag),
    .rsp_last_o(rsp_last), .rsp_from_slow_o(rsp_from_slow), .dec_o(dec)
  );

  assign cfg_thresh = thresh;

  // R4: a port never answers more packets than it was given
  assert_no_spurious_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (zero[1] && !inc[1]) |-> !dec[1]);
endmodule

// File: tb/sim_kv_size_router.sv
`timescale 1ns/1ps
module sim_kv_size_router;
  localparam int DW = 64, TAGW = 6, LENW = 20, PL2 = 12, MAXO = 4;
  localparam int PAGE = 1 << PL2;
  localparam int CYC_LIMIT = 20000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n;
  logic cfg_wr; logic [LENW-1:0] cfg_val; logic [LENW-1:0] cfg_thresh;
  logic req_valid, req_ready, req_write; logic [LENW-1:0] req_len; logic [TAGW-1:0] req_tag;
  logic fast_valid, fast_ready, fast_write; logic [LENW-1:0] fast_len; logic [TAGW-1:0] fast_tag;
  logic slow_valid, slow_ready, slow_write; logic [LENW:0] slow_len; logic [TAGW-1:0] slow_tag;
  logic fr_valid, fr_ready, fr_last; logic [DW-1:0] fr_data; logic [TAGW-1:0] fr_tag;
  logic sr_valid, sr_ready, sr_last; logic [DW-1:0] sr_data; logic [TAGW-1:0] sr_tag;
  logic rsp_valid, rsp_ready, rsp_last, rsp_from_slow;
  logic [DW-1:0] rsp_data; logic [TAGW-1:0] rsp_tag;

  kv_size_router #(.DW(DW), .TAGW(TAGW), .LENW(LENW), .PAGE_LOG2(PL2), .MAX_OUT(MAXO)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_val(cfg_val), .cfg_thresh(cfg_thresh),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write), .req_len(req_len), .req_tag(req_tag),
    .fast_valid(fast_valid), .fast_ready(fast_ready), .fast_write(fast_write), .fast_len(fast_len), .fast_tag(fast_tag),
    .slow_valid(slow_valid), .slow_ready(slow_ready), .slow_write(slow_write), .slow_len(slow_len), .slow_tag(slow_tag),
    .fr_valid(fr_valid), .fr_ready(fr_ready), .fr_data(fr_data), .fr_tag(fr_tag), .fr_last(fr_last),
    .sr_valid(sr_valid), .sr_ready(sr_ready), .sr_data(sr_data), .sr_tag(sr_tag), .sr_last(sr_last),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_tag(rsp_tag),
    .rsp_last(rsp_last), .rsp_from_slow(rsp_from_slow)
  );

  int nchk = 0, nbad = 0;
  bit finished = 0;

  // behavioural reference state
  int m_thresh, m_pval, m_cnt[2];
  bit m_pend, m_hold, m_owner, m_pref;
  // back-end models: per path, FIFO of pending packets
  int q_tag[2][$], q_due[2][$];
  bit b_act[2]; int b_tag[2], b_beat[2], b_nb[2];
  bit slow_hold = 0;
  int cyc = 0, next_tag = 0;
  int req_pct = 60, rsp_pct = 75;
  bit cfg_go = 0; int cfg_next = 0;
  int n_overtake = 0, n_contend = 0, n_fast_while_full = 0, n_park_seen = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", rq, what, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] beat_data(int p, int tag, int beat);
    return {16'hA5C3, 8'(p), 8'(beat), 26'h0, 6'(tag)};
  endfunction

  function automatic int pick_len();
    int k = $urandom % 7;
    int v;
    case (k)
      0: v = $urandom % (m_thresh > 0 ? m_thresh : 1);
      1: v = m_thresh - 1;
      2: v = m_thresh;
      3: v = m_thresh + 1;
      4: v = $urandom % (1 << LENW);
      5: v = ($urandom % 16) * PAGE;
      default: v = $urandom % 512;
    endcase
    if (v < 0) v = 0;
    return v & ((1 << LENW) - 1);
  endfunction

  task automatic drive();
    req_valid  = (($urandom % 100) < req_pct);
    req_write  = $urandom % 2;
    req_len    = LENW'(pick_len());
    req_tag    = TAGW'(next_tag);
    fast_ready = (($urandom % 100) < 85);
    slow_ready = (($urandom % 100) < 80);
    rsp_ready  = (($urandom % 100) < rsp_pct);
    cfg_wr     = cfg_go;
    cfg_val    = LENW'(cfg_next);
    cfg_go     = 0;
    for (int p = 0; p < 2; p++) begin
      if (!b_act[p] && q_tag[p].size() > 0 && q_due[p][0] <= cyc && !(p == 1 && slow_hold)) begin
        b_act[p]  = 1;
        b_tag[p]  = q_tag[p].pop_front();
        void'(q_due[p].pop_front());
        b_beat[p] = 0;
        b_nb[p]   = (p == 0) ? 1 + (b_tag[p] % 3) : 1 + (b_tag[p] % 4);
      end
    end
    fr_valid = b_act[0]; fr_tag = TAGW'(b_tag[0]); fr_last = (b_beat[0] == b_nb[0] - 1);
    fr_data  = beat_data(0, b_tag[0], b_beat[0]);
    sr_valid = b_act[1]; sr_tag = TAGW'(b_tag[1]); sr_last = (b_beat[1] == b_nb[1] - 1);
    sr_data  = beat_data(1, b_tag[1], b_beat[1]);
  endtask

  task automatic step();
    bit to_slow, ef_v, es_v, e_rdy, e_sel, e_rv, e_last, hs_f, hs_s, hs_r;
    int len, e_slen;
    @(negedge clk);
    drive();
    #1;
    len     = int'(req_len);
    to_slow = (len >= m_thresh);
    ef_v    = req_valid && !m_pend && !to_slow && (m_cnt[0] < MAXO);
    es_v    = req_valid && !m_pend && to_slow && (m_cnt[1] < MAXO);
    e_rdy   = !m_pend && (to_slow ? (slow_ready && m_cnt[1] < MAXO) : (fast_ready && m_cnt[0] < MAXO));
    e_slen  = ((len + PAGE - 1) / PAGE) * PAGE;
    if (m_hold) e_sel = m_owner;
    else if (fr_valid && sr_valid) e_sel = m_pref;
    else e_sel = sr_valid;
    if (!m_hold && fr_valid && sr_valid) n_contend++;
    e_rv   = e_sel ? sr_valid : fr_valid;
    e_last = e_sel ? sr_last : fr_last;

    chk(cfg_thresh == LENW'(m_thresh), "R3", "cfg_thresh", cfg_thresh, m_thresh);
    chk(req_ready == e_rdy, m_pend ? "R3" : "R4", "req_ready", req_ready, e_rdy);
    chk(fast_valid == ef_v, "R1", "fast_valid", fast_valid, ef_v);
    chk(slow_valid == es_v, "R2", "slow_valid", slow_valid, es_v);
    if (ef_v) chk(fast_len == req_len && fast_tag == req_tag && fast_write == req_write,
                  "R1", "fast fields", {fast_write, fast_tag, fast_len}, {req_write, req_tag, req_len});
    if (es_v) chk(slow_len == (LENW+1)'(e_slen) && slow_tag == req_tag && slow_write == req_write,
                  "R2", "slow_len", slow_len, e_slen);
    chk(rsp_valid == e_rv, "R5", "rsp_valid", rsp_valid, e_rv);
    chk(fr_ready == (rsp_ready && !e_sel) && sr_ready == (rsp_ready && e_sel),
        "R6", "port ready", {fr_ready, sr_ready}, {rsp_ready && !e_sel, rsp_ready && e_sel});
    if (e_rv) begin
      chk(rsp_from_slow == e_sel, m_hold ? "R8" : "R7", "rsp_from_slow", rsp_from_slow, e_sel);
      chk(rsp_tag == (e_sel ? sr_tag : fr_tag) && rsp_last == e_last
          && rsp_data == (e_sel ? sr_data : fr_data), "R6", "rsp beat", rsp_data,
          e_sel ? sr_data : fr_data);
    end

    // advance the model
    hs_f = ef_v && fast_ready;
    hs_s = es_v && slow_ready;
    hs_r = e_rv && rsp_ready;
    if (hs_r && !e_sel && m_cnt[1] > 0) n_overtake++;
    if (hs_f && m_cnt[1] == MAXO) n_fast_while_full++;
    if (m_pend) n_park_seen++;
    if (cfg_wr) begin m_pend = 1; m_pval = int'(cfg_val); end
    else if (m_pend && m_cnt[0] == 0 && m_cnt[1] == 0) begin m_thresh = m_pval; m_pend = 0; end
    if (hs_f) begin
      m_cnt[0]++; q_tag[0].push_back(next_tag); q_due[0].push_back(cyc + 1 + $urandom % 4);
    end
    if (hs_s) begin
      m_cnt[1]++; q_tag[1].push_back(next_tag); q_due[1].push_back(cyc + 10 + $urandom % 70);
    end
    if (hs_f || hs_s) next_tag = (next_tag + 1) % (1 << TAGW);
    if (hs_r) begin
      if (e_last) begin
        m_cnt[e_sel]--; b_act[e_sel] = 0; m_pref = !e_sel;
      end else b_beat[e_sel]++;
    end
    m_hold = e_rv && !(rsp_ready && e_last);
    if (e_rv) m_owner = e_sel;
    @(posedge clk);
    cyc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(CYC_LIMIT * 4);
    if (!finished) begin
      nbad++; nchk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_wr = 0; cfg_val = '0; req_valid = 0; req_write = 0; req_len = '0; req_tag = '0;
    fast_ready = 0; slow_ready = 0; fr_valid = 0; fr_data = '0; fr_tag = '0; fr_last = 0;
    sr_valid = 0; sr_data = '0; sr_tag = '0; sr_last = 0; rsp_ready = 0;
    m_thresh = PAGE; m_pval = 0; m_cnt[0] = 0; m_cnt[1] = 0;
    m_pend = 0; m_hold = 0; m_owner = 0; m_pref = 0;
    b_act[0] = 0; b_act[1] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(cfg_thresh == LENW'(PAGE), "R3", "reset threshold", cfg_thresh, PAGE);
    chk(rsp_valid == 0 && fast_valid == 0 && slow_valid == 0, "R5", "reset outputs",
        {rsp_valid, fast_valid, slow_valid}, 0);
    @(negedge clk); rst_n = 1;

    run(1500);                                   // mixed traffic, R1 R2 R5 R6 R7 R8 R9
    slow_hold = 1; req_pct = 90; run(300);       // slow port saturates, R4
    chk(n_fast_while_full > 0, "R4", "fast accepts with slow full", n_fast_while_full, 1);
    slow_hold = 0; req_pct = 60;
    cfg_next = 1000; cfg_go = 1; run(500);       // parked update, R3
    chk(m_thresh == 1000, "R3", "threshold applied", m_thresh, 1000);
    cfg_next = 1; cfg_go = 1; run(2);
    cfg_next = 9000; cfg_go = 1; run(500);       // second write overrides first
    rsp_pct = 40; run(800);
    cfg_next = PAGE; cfg_go = 1; rsp_pct = 95; run(1500);
    chk(n_park_seen > 0, "R3", "update parked", n_park_seen, 1);
    chk(n_overtake > 0, "R5", "fast overtakes slow", n_overtake, 1);
    chk(n_contend > 0, "R7", "both ports contended", n_contend, 1);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule